// File: doc/BRIEF.md
# Serial Character Receiver with Line Error Flags

This block turns an asynchronous serial input into characters. A free-running enable (one pulse per oversample period, OVS pulses per bit) paces it. A falling edge on the line is checked again half a bit later before the block accepts it as a start bit. Each later bit is sampled at its centre, least significant bit first. The character holds 5 to 8 data bits. After them comes either an optional parity bit or, in multi-drop mode, a ninth bit that marks an address character.

Each completed character appears on `rx_data` with a one-cycle `rx_valid` strobe. Four sticky error and event flags report line trouble: bad parity, a bad stop bit, a break, and an address character. The host clears each flag by pulsing a one on its bit of `flag_clear`. An address character also raises `addr_enable`. This level stays high until multi-drop mode is switched off. Buffering of characters and generation of the oversample enable are left to neighbouring blocks.

Top module: `serial_rx_core`

## Requirements
- R1: After reset `rx_valid`, `addr_enable` and all four flags are 0.
- R2: A low level that has returned high by the midpoint of the start bit (OVS/2 enables after the falling edge) produces no character and no flag.
- R3: Data bits are taken least significant bit first. `cfg_data_len` sets the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `rx_data` read 0, and `rx_valid` is a single-cycle pulse issued at the middle of the stop bit.
- R4: With `cfg_parity_en`=1 and multi-drop mode off, one parity bit follows the data. With `cfg_parity_odd`=0 the data bits plus the parity bit must hold an even number of ones; with 1 they must hold an odd number. A mismatch sets `flag_parity` one cycle after `rx_valid`.
- R5: A stop bit sampled as 0 sets `flag_frame` one cycle after `rx_valid`.
- R6: `flag_break` is set once the line has stayed low for OVS × (start + data + parity-or-ninth + stop) enables. It is set at most once per low period. Any high level restarts the timer, and a shorter low period does not set it.
- R7: With `cfg_addr_mode`=1 a ninth bit follows the data and appears on `rx_data[8]`, and no parity is checked. A ninth bit of 1 sets `flag_addr` and `addr_enable`. `addr_enable` returns to 0 the cycle after `cfg_addr_mode` is 0.
- R8: Flags hold their value until cleared. `flag_clear` bit 0 clears `flag_parity`, bit 1 clears `flag_frame`, bit 2 clears `flag_break` and bit 3 clears `flag_addr`. A one on a bit clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| sample_tick | input | 1 | Oversample enable, OVS pulses per bit |
| cfg_data_len | input | 2 | Data bit count minus 5 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_addr_mode | input | 1 | Multi-drop mode with ninth address bit |
| flag_clear | input | 4 | Write-one-to-clear strobes for the four flags |
| rx_data | output | 9 | Received character, bit 8 = ninth bit |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| flag_parity | output | 1 | Sticky parity error |
| flag_frame | output | 1 | Sticky framing error |
| flag_break | output | 1 | Sticky break detected |
| flag_addr | output | 1 | Sticky address character seen |
| addr_enable | output | 1 | Address-enable indication |

## Verification
A wrong bit index or a bad end-of-data decision in the character state machine shows up on the next `rx_valid`. It appears as shifted or truncated `rx_data`, or as a spurious parity or framing flag, within one character time. A break timer that fails to restart or saturate shows as `flag_break` arriving early, never arriving, or coming back after a clear during the same low period. That is visible within one to two character times. A stale latched mode bit shows as a missing or extra `flag_addr` or `addr_enable` on the character that follows.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_EXTRA,
      RX_STOP
   } rx_state_t;

   localparam int FLAG_PARITY = 0;
   localparam int FLAG_FRAME  = 1;
   localparam int FLAG_BREAK  = 2;
   localparam int FLAG_ADDR   = 3;
   localparam int NUM_FLAGS   = 4;

   localparam int MIN_DATA_BITS = 5;
   localparam int MAX_FRAME_BITS = 11;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_addr,
   output logic [8:0] char_data,
   output logic       char_valid,
   output logic       err_parity,
   output logic       err_frame,
   output logic       addr_hit
);

   localparam int CNT_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

   rx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bit_idx;
   logic [7:0]       shreg;
   logic             ninth;
   logic [1:0]       len_q;
   logic             par_en_q;
   logic             odd_q;
   logic             addr_q;

   logic             last_data;
   logic             need_extra;
   logic             at_mid;
   logic             at_end;

   assign last_data  = (bit_idx == (3'(len_q) + 3'd4));
   assign need_extra = par_en_q | addr_q;
   assign at_mid     = tick && (cnt == MID_CNT);
   assign at_end     = tick && (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         cnt        <= '0;
         bit_idx    <= '0;
         shreg      <= '0;
         ninth      <= 1'b0;
         len_q      <= '0;
         par_en_q   <= 1'b0;
         odd_q      <= 1'b0;
         addr_q     <= 1'b0;
         char_data  <= '0;
         char_valid <= 1'b0;
         err_parity <= 1'b0;
         err_frame  <= 1'b0;
         addr_hit   <= 1'b0;
      end else begin
         char_valid <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               if (tick && !rx) begin
                  state    <= RX_START;
                  cnt      <= '0;
                  len_q    <= cfg_len;
                  par_en_q <= cfg_par_en & ~cfg_addr;
                  odd_q    <= cfg_par_odd;
                  addr_q   <= cfg_addr;
               end
            end
            RX_START: begin
               if (at_mid) begin
                  cnt <= '0;
                  if (rx) begin
                     state <= RX_IDLE;
                  end else begin
                     state   <= RX_DATA;
                     bit_idx <= '0;
                     shreg   <= '0;
                     ninth   <= 1'b0;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (at_end) begin
                  cnt            <= '0;
                  shreg[bit_idx] <= rx;
                  if (last_data) state <= need_extra ? RX_EXTRA : RX_STOP;
                  else           bit_idx <= bit_idx + 1'b1;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_EXTRA: begin
               if (at_end) begin
                  cnt   <= '0;
                  ninth <= rx;
                  state <= RX_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (at_end) begin
                  cnt        <= '0;
                  state      <= RX_IDLE;
                  char_valid <= 1'b1;
                  char_data  <= {addr_q & ninth, shreg};
                  err_parity <= par_en_q & ((^shreg ^ ninth) != odd_q);
                  err_frame  <= ~rx;
                  addr_hit   <= addr_q & ninth;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break
   import serial_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] cfg_len,
   input  logic       cfg_extra,
   output logic       break_hit
);

   localparam int TMR_W = $clog2(OVS * MAX_FRAME_BITS + 1);

   logic [TMR_W-1:0] timer;
   logic [TMR_W-1:0] limit;

   always_comb begin
      limit = TMR_W'(OVS * (32'(cfg_len) + 32'd7 + 32'(cfg_extra)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer     <= '0;
         break_hit <= 1'b0;
      end else begin
         break_hit <= 1'b0;
         if (rx) begin
            timer <= '0;
         end else if (tick && (timer < limit)) begin
            timer <= timer + 1'b1;
            if (timer == limit - 1'b1) break_hit <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic         addr_set_i,
   input  logic         mode_i,
   output logic [N-1:0] flags_o,
   output logic         addr_en_o
);

   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr_i[g]) | set_i[g];
         end
         assign flags_o[g] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_en_o <= 1'b0;
      else if (!mode_i) addr_en_o <= 1'b0;
      else if (addr_set_i) addr_en_o <= 1'b1;
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import serial_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_line,
   input  logic       sample_tick,
   input  logic [1:0] cfg_data_len,
   input  logic       cfg_parity_en,
   input  logic       cfg_parity_odd,
   input  logic       cfg_addr_mode,
   input  logic [3:0] flag_clear,
   output logic [8:0] rx_data,
   output logic       rx_valid,
   output logic       flag_parity,
   output logic       flag_frame,
   output logic       flag_break,
   output logic       flag_addr,
   output logic       addr_enable
);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("serial_rx_core: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("serial_rx_core: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic                 rx_s;
   logic                 err_par;
   logic                 err_frm;
   logic                 addr_hit;
   logic                 brk_hit;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_vec;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_line),
      .dout  (rx_s)
   );

   serial_rx_frame #(.OVS(OVS)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (sample_tick),
      .rx          (rx_s),
      .cfg_len     (cfg_data_len),
      .cfg_par_en  (cfg_parity_en),
      .cfg_par_odd (cfg_parity_odd),
      .cfg_addr    (cfg_addr_mode),
      .char_data   (rx_data),
      .char_valid  (rx_valid),
      .err_parity  (err_par),
      .err_frame   (err_frm),
      .addr_hit    (addr_hit)
   );

   serial_rx_break #(.OVS(OVS)) u_break (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .rx        (rx_s),
      .cfg_len   (cfg_data_len),
      .cfg_extra (cfg_parity_en | cfg_addr_mode),
      .break_hit (brk_hit)
   );

   always_comb begin
      flag_set              = '0;
      flag_set[FLAG_PARITY] = rx_valid & err_par;
      flag_set[FLAG_FRAME]  = rx_valid & err_frm;
      flag_set[FLAG_BREAK]  = brk_hit;
      flag_set[FLAG_ADDR]   = rx_valid & addr_hit;
   end

   serial_rx_flags #(.N(NUM_FLAGS)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (flag_set),
      .clr_i      (flag_clear),
      .addr_set_i (flag_set[FLAG_ADDR]),
      .mode_i     (cfg_addr_mode),
      .flags_o    (flag_vec),
      .addr_en_o  (addr_enable)
   );

   assign flag_parity = flag_vec[FLAG_PARITY];
   assign flag_frame  = flag_vec[FLAG_FRAME];
   assign flag_break  = flag_vec[FLAG_BREAK];
   assign flag_addr   = flag_vec[FLAG_ADDR];

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_addr_mode,
   input logic [3:0] flag_clear,
   input logic       rx_valid,
   input logic       flag_parity,
   input logic       flag_frame,
   input logic       flag_break,
   input logic       flag_addr,
   input logic       addr_enable
);

   // R3: character strobe lasts one cycle
   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4: a parity flag only rises right after a character
   p_parity_after_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_parity) |-> $past(rx_valid));

   // R5: a framing flag only rises right after a character
   p_frame_after_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_frame) |-> $past(rx_valid));

   // R7: address flag comes with the enable indication
   p_addr_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_addr) && $past(cfg_addr_mode)) |-> addr_enable);

   // R7: leaving multi-drop mode drops the enable
   p_addr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_addr_mode |=> !addr_enable);

   // R8: clearing the parity flag without a new character empties it
   p_clear_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_parity && flag_clear[0] && !rx_valid) |=> !flag_parity);

   // R8: flags stay set while not cleared
   p_sticky_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_frame && !flag_clear[1]) |=> flag_frame);

   p_sticky_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_break && !flag_clear[2]) |=> flag_break);

endmodule

bind serial_rx_core serial_rx_core_chk u_chk (.*);

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;

   localparam int OVS      = 16;
   localparam int TICK_DIV = 4;
   localparam int BIT_CLKS = OVS * TICK_DIV;

   // [15:14] len code, [13] parity en, [12] odd, [11] addr mode,
   // [10] corrupt parity, [9] bad stop, [8:0] data
   localparam logic [15:0] VECS [8] = '{
      {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
      {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1F3},
      {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
      {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h03C},
      {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h02A},
      {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h1C3},
      {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h044},
      {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h081}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       sample_tick = 1'b0;
   logic [1:0] cfg_data_len = 2'd3;
   logic       cfg_parity_en = 1'b0;
   logic       cfg_parity_odd = 1'b0;
   logic       cfg_addr_mode = 1'b0;
   logic [3:0] flag_clear = 4'h0;
   logic [8:0] rx_data;
   logic       rx_valid;
   logic       flag_parity, flag_frame, flag_break, flag_addr, addr_enable;

   int checks = 0;
   int fails = 0;
   int vcount = 0;
   int tdiv = 0;

   always #2.5 clk = ~clk;

   serial_rx_core #(.OVS(OVS), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .sample_tick(sample_tick),
      .cfg_data_len(cfg_data_len), .cfg_parity_en(cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd), .cfg_addr_mode(cfg_addr_mode),
      .flag_clear(flag_clear), .rx_data(rx_data), .rx_valid(rx_valid),
      .flag_parity(flag_parity), .flag_frame(flag_frame),
      .flag_break(flag_break), .flag_addr(flag_addr), .addr_enable(addr_enable)
   );

   always @(posedge clk) begin
      tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      sample_tick <= (tdiv == TICK_DIV - 1);
      if (rx_valid) vcount <= vcount + 1;
   end

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int nbits);
      rx_line = v;
      repeat (nbits * BIT_CLKS) @(negedge clk);
   endtask

   task automatic clear_all();
      cfg_addr_mode = 1'b0;
      flag_clear = 4'hF;
      @(negedge clk);
      flag_clear = 4'h0;
      @(negedge clk);
   endtask

   task automatic run_frame(input logic [15:0] v, input bit do_clear);
      int nbits;
      logic [8:0] d, exp_d;
      logic [7:0] mask;
      logic pbit;
      int t;
      d = v[8:0];
      nbits = 32'(v[15:14]) + 5;
      mask = 8'((1 << nbits) - 1);
      @(negedge clk);
      cfg_data_len = v[15:14];
      cfg_parity_en = v[13];
      cfg_parity_odd = v[12];
      cfg_addr_mode = v[11];
      exp_d = v[11] ? {d[8], d[7:0] & mask} : {1'b0, d[7:0] & mask};
      pbit = (^(d[7:0] & mask)) ^ v[12] ^ v[10];
      hold(1'b0, 1);
      for (int i = 0; i < nbits; i++) hold(d[i], 1);
      if (v[11])      hold(d[8], 1);
      else if (v[13]) hold(pbit, 1);
      rx_line = ~v[9];
      t = 0;
      while (rx_valid !== 1'b1 && t < 3 * BIT_CLKS) begin
         @(negedge clk);
         t++;
      end
      check("R3", "strobe seen", {15'd0, rx_valid}, 16'd1);
      check(v[11] ? "R7" : "R3", "rx_data", {7'd0, rx_data}, {7'd0, exp_d});
      @(negedge clk);
      check("R3", "strobe single", {15'd0, rx_valid}, 16'd0);
      check("R4", "flag_parity", {15'd0, flag_parity},
            {15'd0, v[13] & ~v[11] & v[10]});
      check("R5", "flag_frame", {15'd0, flag_frame}, {15'd0, v[9]});
      check("R7", "flag_addr", {15'd0, flag_addr}, {15'd0, v[11] & d[8]});
      check("R7", "addr_enable", {15'd0, addr_enable}, {15'd0, v[11] & d[8]});
      rx_line = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);
      if (do_clear) begin
         clear_all();
         check("R8", "all flags cleared",
               {12'd0, flag_addr, flag_break, flag_frame, flag_parity}, 16'd0);
         check("R7", "addr_enable off", {15'd0, addr_enable}, 16'd0);
      end
   endtask

   initial begin
      #(5.0 * 190000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int vc;
      repeat (5) @(negedge clk);
      // R1: reset state
      check("R1", "outputs in reset",
            {10'd0, rx_valid, addr_enable, flag_addr, flag_break, flag_frame, flag_parity}, 16'd0);
      rst_n = 1'b1;
      repeat (3 * BIT_CLKS) @(negedge clk);
      check("R1", "outputs after reset",
            {10'd0, rx_valid, addr_enable, flag_addr, flag_break, flag_frame, flag_parity}, 16'd0);

      for (int k = 0; k < 8; k++) run_frame(VECS[k], 1'b1);

      // R8: selective clear leaves the other flag
      run_frame(VECS[7], 1'b0);
      flag_clear = 4'b0001;
      @(negedge clk);
      flag_clear = 4'h0;
      @(negedge clk);
      check("R8", "parity cleared", {15'd0, flag_parity}, 16'd0);
      check("R8", "frame kept", {15'd0, flag_frame}, 16'd1);
      clear_all();

      // R2: short low glitch rejected at start midpoint
      vc = vcount;
      rx_line = 1'b0;
      repeat (3 * TICK_DIV) @(negedge clk);
      rx_line = 1'b1;
      repeat (15 * BIT_CLKS) @(negedge clk);
      check("R2", "no character from glitch", 16'(vcount - vc), 16'd0);
      check("R2", "no flags from glitch",
            {12'd0, flag_addr, flag_break, flag_frame, flag_parity}, 16'd0);

      // R6: break timing, 8 data bits no parity -> 10 bit times
      cfg_data_len = 2'd3; cfg_parity_en = 1'b0; cfg_addr_mode = 1'b0;
      hold(1'b0, 9);
      hold(1'b1, 3);
      check("R6", "short low no break", {15'd0, flag_break}, 16'd0);
      hold(1'b0, 13);
      check("R6", "long low sets break", {15'd0, flag_break}, 16'd1);
      flag_clear = 4'b0100;
      @(negedge clk);
      flag_clear = 4'h0;
      hold(1'b0, 13);
      check("R6", "once per low period", {15'd0, flag_break}, 16'd0);
      hold(1'b1, 3);
      hold(1'b0, 13);
      check("R6", "timer restarts after high", {15'd0, flag_break}, 16'd1);
      hold(1'b1, 3);
      clear_all();
      check("R8", "break cleared", {15'd0, flag_break}, 16'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule